// File: doc/BRIEF.md
# SPI NOR Programmed Command Shifter

This block issues short, software-defined commands to a serial NOR flash over a single-lane SPI link in mode 0 and captures whatever the flash drives back. Software fills a six-byte transmit frame through a byte-wide register bus. The top frame byte holds the opcode and the lower bytes hold its arguments. Software then writes the number of bits to clock and finally a command code. The engine lowers chip select, shifts the frame out most significant bit first, samples the return line into a receive bank, and clears the command code when the transfer has finished. Software polls the command register until it reads zero.

Two fixed operations sit beside the generic transfer. The status read sends the flash's status-read opcode and stores the byte that follows in its own result register. The status write sends the flash's status-write opcode followed by the opcode-slot byte. Both operations use a fixed 16-bit length, whatever the count register holds.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, chip select (`cs_n_o`) is high, `sclk_o` is low and the command register (address 0x00) reads 0x00.
- R2: Command 0x04 with count 8 shifts out only the byte at address 0x0D (frame slot 5, the opcode), MSB first. MOSI is stable while SCLK is high, and exactly 8 SCLK rising edges occur.
- R3: Command 0x04 with count N clocks N bits. The slots go out in descending order: 0x0D, 0x0C, 0x0B, down to 0x08. The receive bank starts from zero, and the last N sampled bits are right-aligned in it. The last byte received reads at 0x10 (receive slot 0), the byte before it at 0x11, and so on up to 0x15.
- R4: A count of 48 sends all six frame slots and fills all six receive slots.
- R5: Command 0x02 sends opcode 0x05 followed by 8 zero bits, 16 edges in all. The second received byte is stored at address 0x02 (status result).
- R6: Command 0x20 sends opcode 0x01 followed by the byte at 0x0D, 16 edges in all. It leaves the receive bank and the status result unchanged.
- R7: Command 0x04 with a count (address 0x01) of 0, or of more than 48, completes at once. The command register reads 0 on the next read, and chip select never falls.
- R8: A command write while the command register is nonzero is ignored. The running transfer keeps its bit count and its data, and no second transfer starts.
- R9: While a transfer runs, the command register reads the code that was written. It returns to 0x00 within one cycle after chip select rises.
- R10: Chip select falls DIV+DIV/2 system clocks before the first SCLK rising edge and rises DIV clocks after the last SCLK falling edge. SCLK is low whenever chip select is high.
- R11: A count that is not a multiple of 8 leaves a partial byte in the receive bank. For example, with count 12, slot 0 holds the last 8 bits and slot 1 holds the first 4 bits in its low nibble.
- R12: A write to address 0x00 of any value other than 0x04, 0x02 or 0x20 starts nothing and leaves the register at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Flash chip select, active low |
| mosi_o | output | 1 | Serial data to the flash |
| miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach from the ports is a command write that lands while a transfer is still shifting. It must neither restart the engine nor change the operation that is recorded for commit when the transfer finishes. The stimulus starts a 16-bit programmed transfer, reads the busy code back, and writes a status-read command while the bits are still going out. A scoreboard then checks that only the original 16 bits appeared on MOSI and that the status result kept its earlier value. A flash model drives known response patterns so that the position of every captured byte, including a partial one, can be predicted.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_BITS  = FRAME_BYTES * 8;
  localparam int BITS_W      = $clog2(FRAME_BITS + 1);

  localparam logic [7:0] CODE_PROG = 8'h04;
  localparam logic [7:0] CODE_RDSR = 8'h02;
  localparam logic [7:0] CODE_WRSR = 8'h20;

  localparam logic [7:0] FLASH_OP_RDSR = 8'h05;
  localparam logic [7:0] FLASH_OP_WRSR = 8'h01;

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_state_e;
endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/spi_serial_engine.sv
module spi_serial_engine
  import spi_cmd_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic [BITS_W-1:0]     nbits_i,
  output logic                  done_o,
  output logic [FRAME_BITS-1:0] rx_o,
  output logic                  sclk_o,
  output logic                  cs_n_o,
  output logic                  mosi_o,
  input  logic                  miso_i
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HIGH = PH_W'(DIV / 2);
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(DIV / 2 - 1);

  eng_state_e            state_q, state_d;
  logic [PH_W-1:0]       phase_q, phase_d;
  logic [BITS_W-1:0]     bit_q, bit_d, nbits_q, nbits_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d, rx_q, rx_d;
  logic                  sclk_q, sclk_d, cs_n_q, cs_n_d, done_q, done_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    nbits_d = nbits_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LEAD;
          phase_d = '0;
          bit_d   = '0;
          nbits_d = nbits_i;
          tx_d    = frame_i;
          rx_d    = '0;
          cs_n_d  = 1'b0;
        end
      end
      ST_LEAD: begin
        if (phase_q == PH_LAST) begin
          state_d = ST_SHIFT;
          phase_d = '0;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (phase_q == PH_HIGH) rx_d = {rx_q[FRAME_BITS-2:0], miso_i};
        if (phase_q == PH_LAST) begin
          phase_d = '0;
          sclk_d  = 1'b0;
          tx_d    = {tx_q[FRAME_BITS-2:0], 1'b0};
          if (bit_q == nbits_q - 1'b1) state_d = ST_TRAIL;
          else                         bit_d   = bit_q + 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
          if (phase_q == PH_PRE) sclk_d = 1'b1;
        end
      end
      ST_TRAIL: begin
        if (phase_q == PH_LAST) begin
          state_d = ST_IDLE;
          phase_d = '0;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      nbits_q <= nbits_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = tx_q[FRAME_BITS-1];
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  eng_start,
  output logic [FRAME_BITS-1:0] eng_frame,
  output logic [BITS_W-1:0]     eng_nbits,
  input  logic                  eng_done,
  input  logic [FRAME_BITS-1:0] eng_rx,
  output logic [7:0]            cmd_bits
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam int A_TX = 8;
  localparam int A_RX = 16;

  logic [7:0] tx_q [FRAME_BYTES];
  logic [7:0] tx_d [FRAME_BYTES];
  logic [7:0] rx_q [FRAME_BYTES];
  logic [7:0] rx_d [FRAME_BYTES];
  logic [7:0] cmd_q, cmd_d, cnt_q, cnt_d, stat_q, stat_d;
  logic       cnt_ok;
  logic [FRAME_BITS-1:0] tx_flat;

  assign cnt_ok = (cnt_q != 8'd0) && (cnt_q <= 8'(FRAME_BITS));

  always_comb begin
    for (int i = 0; i < FRAME_BYTES; i++) tx_flat[8*i +: 8] = tx_q[i];
  end

  always_comb begin
    cmd_d     = cmd_q;
    cnt_d     = cnt_q;
    stat_d    = stat_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    eng_start = 1'b0;
    eng_frame = tx_flat;
    eng_nbits = cnt_q[BITS_W-1:0];
    if (bus_wr && bus_addr == A_CNT) cnt_d = bus_wdata;
    for (int i = 0; i < FRAME_BYTES; i++)
      if (bus_wr && bus_addr == ADDR_W'(A_TX + i)) tx_d[i] = bus_wdata;
    if (eng_done) begin
      if (cmd_q == CODE_PROG)
        for (int i = 0; i < FRAME_BYTES; i++) rx_d[i] = eng_rx[8*i +: 8];
      if (cmd_q == CODE_RDSR) stat_d = eng_rx[7:0];
      cmd_d = 8'h00;
    end else if (bus_wr && bus_addr == A_CMD && cmd_q == 8'h00) begin
      if (bus_wdata == CODE_PROG && cnt_ok) begin
        eng_start = 1'b1;
        cmd_d     = bus_wdata;
      end else if (bus_wdata == CODE_RDSR) begin
        eng_start = 1'b1;
        eng_frame = {FLASH_OP_RDSR, {(FRAME_BITS-8){1'b0}}};
        eng_nbits = BITS_W'(16);
        cmd_d     = bus_wdata;
      end else if (bus_wdata == CODE_WRSR) begin
        eng_start = 1'b1;
        eng_frame = {FLASH_OP_WRSR, tx_q[FRAME_BYTES-1], {(FRAME_BITS-16){1'b0}}};
        eng_nbits = BITS_W'(16);
        cmd_d     = bus_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 8'h00;
      cnt_q  <= 8'h00;
      stat_q <= 8'h00;
      for (int i = 0; i < FRAME_BYTES; i++) begin
        tx_q[i] <= 8'h00;
        rx_q[i] <= 8'h00;
      end
    end else begin
      cmd_q  <= cmd_d;
      cnt_q  <= cnt_d;
      stat_q <= stat_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_addr == A_CMD)  bus_rdata = cmd_q;
    if (bus_addr == A_CNT)  bus_rdata = cnt_q;
    if (bus_addr == A_STAT) bus_rdata = stat_q;
    for (int i = 0; i < FRAME_BYTES; i++) begin
      if (bus_addr == ADDR_W'(A_TX + i)) bus_rdata = tx_q[i];
      if (bus_addr == ADDR_W'(A_RX + i)) bus_rdata = rx_q[i];
    end
  end

  assign cmd_bits = cmd_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int DIV    = 4,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic                  rst_n_s;
  logic                  eng_start, eng_done;
  logic [FRAME_BITS-1:0] eng_frame, eng_rx;
  logic [BITS_W-1:0]     eng_nbits;
  logic [7:0]            cmd_bits;

  spi_rst_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  spi_cmd_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
    .eng_frame(eng_frame), .eng_nbits(eng_nbits), .eng_done(eng_done),
    .eng_rx(eng_rx), .cmd_bits(cmd_bits)
  );

  spi_serial_engine #(.DIV(DIV)) eng_i (
    .clk(clk), .rst_n(rst_n_s), .start_i(eng_start), .frame_i(eng_frame),
    .nbits_i(eng_nbits), .done_o(eng_done), .rx_o(eng_rx), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
module spi_cmd_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd_bits,
  input logic       sclk_o,
  input logic       cs_n_o,
  input logic       mosi_o
);
  // R1
  idle_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits == 8'h00) |-> cs_n_o);

  // R10
  sclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_bits != 8'h00) |=> (cmd_bits == $past(cmd_bits) || cmd_bits == 8'h00));

  // R9
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |=> (cmd_bits == 8'h00));
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk chk_i (
  .clk(clk), .rst_n(rst_n_s), .cmd_bits(cmd_bits),
  .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o)
);

// File: tb/spi_cmd_shifter_tb.sv
`timescale 1ns/1ps
module spi_cmd_shifter_tb_top;
  localparam int DIV = 4;
  localparam realtime TCLK = 5.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk_o, cs_n_o, mosi_o;
  logic       miso_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic exp_q[$];
  logic [47:0] flash_resp = '0;
  int bit_i = 0;
  int edges = 0;
  int cs_falls = 0;
  realtime t_csfall, t_first_rise, t_last_fall, t_csrise;
  bit first_rise = 1'b0;

  always #(TCLK/2) clk = ~clk;

  spi_cmd_shifter #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // flash model and scoreboard monitor
  always @(negedge cs_n_o) begin
    if (rst_n) begin
      cs_falls++;
      bit_i = 0;
      miso_i = flash_resp[47];
      t_csfall = $realtime;
      first_rise = 1'b1;
    end
  end
  always @(posedge cs_n_o) t_csrise = $realtime;
  always @(negedge sclk_o) begin
    bit_i++;
    if (bit_i < 48) miso_i = flash_resp[47 - bit_i];
    t_last_fall = $realtime;
  end
  always @(posedge sclk_o) begin
    logic e;
    edges++;
    if (first_rise) begin
      t_first_rise = $realtime;
      first_rise = 1'b0;
    end
    if (exp_q.size() == 0) begin
      check(1'b0, "R8 unexpected SCLK edge", 64'(mosi_o), 64'hx);
    end else begin
      e = exp_q.pop_front();
      check(mosi_o == e, "R2/R3 MOSI bit", 64'(mosi_o), 64'(e));
    end
  end

  task automatic push_bits(input logic [47:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v[47 - i]);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int k = 0; k < 2000; k++) begin
      bus_read(5'h00, c);
      if (c == 8'h00) break;
    end
  endtask

  task automatic run_cmd(input logic [7:0] code, input int n, input string req);
    edges = 0;
    bus_write(5'h00, code);
    wait_idle();
    check(edges == n, req, 64'(edges), 64'(n));
    check(exp_q.size() == 0, req, 64'(exp_q.size()), 64'd0);
  endtask

  task automatic check_rx(input logic [47:0] exp, input string req);
    logic [7:0] d;
    for (int i = 0; i < 6; i++) begin
      bus_read(5'(16 + i), d);
      check(d == exp[8*i +: 8], req, 64'(d), 64'(exp[8*i +: 8]));
    end
  endtask

  initial begin
    #(200000 * TCLK);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(cs_n_o == 1'b1, "R1 cs_n", 64'(cs_n_o), 64'd1);
    check(sclk_o == 1'b0, "R1 sclk", 64'(sclk_o), 64'd0);
    bus_read(5'h00, d);
    check(d == 8'h00, "R1 cmd", 64'(d), 64'd0);

    // R2 opcode only, also R10 framing
    bus_write(5'h0D, 8'h06);
    bus_write(5'h01, 8'd8);
    push_bits({8'h06, 40'h0}, 8);
    run_cmd(8'h04, 8, "R2 edges");
    check(t_first_rise - t_csfall == (DIV + DIV/2) * TCLK, "R10 lead",
          64'(int'(t_first_rise - t_csfall)), 64'(int'((DIV + DIV/2) * TCLK)));
    check(t_csrise - t_last_fall == DIV * TCLK, "R10 trail",
          64'(int'(t_csrise - t_last_fall)), 64'(int'(DIV * TCLK)));

    // R3 opcode + 3 bytes, 32 bits
    bus_write(5'h0D, 8'h03);
    bus_write(5'h0C, 8'h12);
    bus_write(5'h0B, 8'h34);
    bus_write(5'h0A, 8'h56);
    bus_write(5'h01, 8'd32);
    flash_resp = 48'hA1B2C3D4E5F6;
    push_bits({8'h03, 8'h12, 8'h34, 8'h56, 16'h0}, 32);
    run_cmd(8'h04, 32, "R3 edges");
    check_rx(48'h0000A1B2C3D4, "R3 rx bank");

    // R4 full frame
    bus_write(5'h09, 8'h9A);
    bus_write(5'h08, 8'hBC);
    bus_write(5'h01, 8'd48);
    flash_resp = 48'h0F1E2D3C4B5A;
    push_bits({8'h03, 8'h12, 8'h34, 8'h56, 8'h9A, 8'hBC}, 48);
    run_cmd(8'h04, 48, "R4 edges");
    check_rx(48'h0F1E2D3C4B5A, "R4 rx bank");

    // R11 partial byte
    bus_write(5'h01, 8'd12);
    flash_resp = 48'hABC000000000;
    push_bits({8'h03, 8'h12, 32'h0}, 12);
    run_cmd(8'h04, 12, "R11 edges");
    check_rx(48'h000000000ABC, "R11 rx bank");

    // R5 status read
    flash_resp = 48'h775C00000000;
    push_bits({8'h05, 8'h00, 32'h0}, 16);
    run_cmd(8'h02, 16, "R5 edges");
    bus_read(5'h02, d);
    check(d == 8'h5C, "R5 status result", 64'(d), 64'h5C);

    // R6 status write
    bus_write(5'h0D, 8'h3A);
    flash_resp = 48'hFFFFFFFFFFFF;
    push_bits({8'h01, 8'h3A, 32'h0}, 16);
    run_cmd(8'h20, 16, "R6 edges");
    bus_read(5'h02, d);
    check(d == 8'h5C, "R6 status kept", 64'(d), 64'h5C);
    check_rx(48'h000000000ABC, "R6 rx bank kept");

    // R7 zero and oversize counts
    cf = cs_falls;
    bus_write(5'h01, 8'd0);
    bus_write(5'h00, 8'h04);
    bus_read(5'h00, d);
    check(d == 8'h00, "R7 count 0 cmd", 64'(d), 64'd0);
    bus_write(5'h01, 8'd49);
    bus_write(5'h00, 8'h04);
    bus_read(5'h00, d);
    check(d == 8'h00, "R7 count 49 cmd", 64'(d), 64'd0);
    repeat (20) @(negedge clk);
    check(cs_falls == cf, "R7 no chip select", 64'(cs_falls), 64'(cf));

    // R12 unknown code
    bus_write(5'h00, 8'h08);
    bus_read(5'h00, d);
    check(d == 8'h00, "R12 unknown code", 64'(d), 64'd0);
    repeat (20) @(negedge clk);
    check(cs_falls == cf, "R12 no chip select", 64'(cs_falls), 64'(cf));

    // R8 / R9 command while busy
    bus_write(5'h0D, 8'hC3);
    bus_write(5'h0C, 8'h3C);
    bus_write(5'h01, 8'd16);
    flash_resp = 48'h123400000000;
    push_bits({8'hC3, 8'h3C, 32'h0}, 16);
    edges = 0;
    cf = cs_falls;
    bus_write(5'h00, 8'h04);
    bus_read(5'h00, d);
    check(d == 8'h04, "R9 busy code", 64'(d), 64'h04);
    bus_write(5'h00, 8'h02);
    bus_read(5'h00, d);
    check(d == 8'h04, "R8 code kept", 64'(d), 64'h04);
    wait_idle();
    repeat (4 * DIV) @(negedge clk);
    check(edges == 16, "R8 edges", 64'(edges), 64'd16);
    check(cs_falls == cf + 1, "R8 one transfer", 64'(cs_falls), 64'(cf + 1));
    bus_read(5'h02, d);
    check(d == 8'h5C, "R8 status untouched", 64'(d), 64'h5C);
    check_rx(48'h000000001234, "R8 rx bank");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule